// File: doc/BRIEF.md
# Serial EEPROM Command Sequencer

This block is the device side of a three-wire serial EEPROM port: a chip select, a serial clock, a serial data input and a serial data output. It decodes framed commands arriving on the data input and keeps a small word-organised storage array in flip-flops. It supports single-word write, single-word erase and an unbounded sequential read. It also keeps a write-enable latch that gates every modifying command. The serial pins are sampled with the block's system clock, so the serial clock must run well below the system clock.

A command begins with a 1 start bit. Two opcode bits follow, then the address, each field most significant bit first. A write carries a data word after the address. Writes and erases do not finish at the end of the frame. They are committed when chip select falls, and then a self-timed programming period begins. Its length is a fixed number of system clocks. During that period the data output reports busy whenever chip select is high. Once the period ends it reports ready. The serial data output is modelled as a value plus an output-enable.

Top module: `sereep_seq`

## Requirements
- R1: After reset the output-enable is low, the write-enable latch is clear and every storage word reads as zero.
- R2: While chip select is high, zeros clocked before the start bit are skipped. After the start bit the block takes two opcode bits and then 8 address bits, both most significant bit first. Opcodes: 10 read, 01 write, 11 erase, 00 latch control.
- R3: On the rising serial clock edge that samples the last address bit of a read, the block enables the output and drives a single 0 for one serial clock period. The 16 bits of the addressed word then follow, most significant bit first, each launched on a rising serial clock edge.
- R4: While chip select stays high, a read continues with the word at the next address without any 0 bit between words, and the address wraps from 8'hFF to 8'h00.
- R5: A latch-control command whose address begins with bits 11 sets the write-enable latch, and one whose address begins with 00 clears it. While the latch is clear, write and erase commands change no storage and start no programming period.
- R6: A read returns stored data whether the write-enable latch is set or clear.
- R7: A write or erase commits only if the write-enable input was high for the whole command, from the start bit to the fall of chip select.
- R8: A programming period starts only when chip select falls after the last bit of a complete write or erase frame and before any further rising serial clock edge. A further rising edge cancels the command.
- R9: During the programming period, a high chip select enables the output and drives it 0. Every start bit and command is ignored during that period.
- R10: When no command is in progress and no programming period is running, a high chip select drives the output 1. A programming period lasts PROG_CYCLES system clocks, after which commands are accepted again without lowering chip select.
- R11: An erase sets every bit of the addressed word to 1.
- R12: A low chip select disables the output and ends any command that is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| csIn | input | 1 | Serial chip select, active high |
| sclkIn | input | 1 | Serial clock |
| dIn | input | 1 | Serial data input |
| weIn | input | 1 | Write-enable pin, must be high for a write to commit |
| doOut | output | 1 | Serial data output value |
| doOe | output | 1 | Output-enable for doOut |

## Verification
The hardest state to reach is one where chip select is raised and a complete, well-formed read frame is clocked in while a programming period is still running. Telling an ignored frame apart from a serviced one needs a word whose leading bit is 1. The bench first programs such a word. It then clocks the read frame plus one extra bit during the busy window and checks that the output stays at the busy 0. Keeping chip select high, it waits for ready, measures the period against PROG_CYCLES, and checks that a fresh read is accepted right away. The cancelled-frame and write-enable-pin cases are driven with the same tasks: the bench adds one serial clock edge, or drops the pin in the middle of the data field, and then reads the word back.

// File: rtl/sereep_pkg.sv
package sereep_pkg;

  typedef enum logic [1:0] {
    OUT_OFF,
    OUT_STATUS,
    OUT_READ
  } outMode_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_READ,
    ST_ARM,
    ST_HOLD
  } seqState_t;

  localparam logic [1:0] OP_LATCH = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  typedef struct packed {
    logic addrShift;
    logic dataShift;
    logic readLoad;
    logic readStep;
    logic memWrite;
    logic eraseSel;
  } dpStrobe_t;

endpackage

// File: rtl/sereep_sync.sv
module sereep_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe[0] <= '0;
    else       pipe[0] <= rawIn;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe[g] <= '0;
      else       pipe[g] <= pipe[g-1];
    end
  end

  assign syncOut = pipe[STAGES-1];

endmodule

// File: rtl/sereep_ctrl.sv
module sereep_ctrl
  import sereep_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 400
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csS,
  input  logic       sclkS,
  input  logic       dS,
  input  logic       weS,
  input  logic [1:0] addrHigh,
  output dpStrobe_t  stb,
  output outMode_t   mode,
  output logic       progBusy,
  output logic       welLatch
);

  localparam int MAX_W  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int CNT_W  = $clog2(MAX_W);
  localparam int PROG_W = $clog2(PROG_CYCLES + 1);

  seqState_t         state, stateNext;
  logic [CNT_W-1:0]  bitCnt, cntNext;
  logic [1:0]        opcode, opNext;
  logic              sclkPrev, csPrev;
  logic              weBad;
  logic [PROG_W-1:0] progCnt;
  logic              launch, setWel, clrWel;
  logic              sclkRise, csFall;

  assign sclkRise = sclkS & ~sclkPrev;
  assign csFall   = ~csS & csPrev;

  always_comb begin
    stb       = '0;
    stateNext = state;
    cntNext   = bitCnt;
    opNext    = opcode;
    launch    = 1'b0;
    setWel    = 1'b0;
    clrWel    = 1'b0;
    if (!csS) begin
      stateNext = ST_IDLE;
      if (csFall && state == ST_ARM && welLatch && !weBad && weS) begin
        launch       = 1'b1;
        stb.memWrite = 1'b1;
        stb.eraseSel = (opcode == OP_ERASE);
      end
    end else if (sclkRise) begin
      unique case (state)
        ST_IDLE: begin
          if (dS && !progBusy) begin
            stateNext = ST_OPC;
            cntNext   = '0;
          end
        end
        ST_OPC: begin
          opNext = {opcode[0], dS};
          if (bitCnt == CNT_W'(1)) begin
            stateNext = ST_ADDR;
            cntNext   = '0;
          end else begin
            cntNext = bitCnt + 1'b1;
          end
        end
        ST_ADDR: begin
          stb.addrShift = 1'b1;
          if (bitCnt == CNT_W'(ADDR_W - 1)) begin
            cntNext = '0;
            unique case (opcode)
              OP_READ: begin
                stb.readLoad = 1'b1;
                stateNext    = ST_READ;
              end
              OP_WRITE: stateNext = ST_DATA;
              OP_ERASE: stateNext = ST_ARM;
              default: begin
                if (addrHigh == 2'b11)      setWel = 1'b1;
                else if (addrHigh == 2'b00) clrWel = 1'b1;
                stateNext = ST_HOLD;
              end
            endcase
          end else begin
            cntNext = bitCnt + 1'b1;
          end
        end
        ST_DATA: begin
          stb.dataShift = 1'b1;
          if (bitCnt == CNT_W'(DATA_W - 1)) begin
            stateNext = ST_ARM;
            cntNext   = '0;
          end else begin
            cntNext = bitCnt + 1'b1;
          end
        end
        ST_READ: stb.readStep = 1'b1;
        ST_ARM:  stateNext = ST_HOLD;
        default: stateNext = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      opcode   <= '0;
      sclkPrev <= 1'b0;
      csPrev   <= 1'b0;
      weBad    <= 1'b0;
      welLatch <= 1'b0;
      progBusy <= 1'b0;
      progCnt  <= '0;
      mode     <= OUT_OFF;
    end else begin
      state    <= stateNext;
      bitCnt   <= cntNext;
      opcode   <= opNext;
      sclkPrev <= sclkS;
      csPrev   <= csS;

      if (state == ST_IDLE && stateNext == ST_OPC) weBad <= ~weS;
      else if (state != ST_IDLE && !weS)           weBad <= 1'b1;

      if (setWel)      welLatch <= 1'b1;
      else if (clrWel) welLatch <= 1'b0;

      if (launch) begin
        progBusy <= 1'b1;
        progCnt  <= PROG_W'(PROG_CYCLES - 1);
      end else if (progBusy) begin
        if (progCnt == '0) progBusy <= 1'b0;
        else               progCnt  <= progCnt - 1'b1;
      end

      if (!csS)                         mode <= OUT_OFF;
      else if (stateNext == ST_READ)    mode <= OUT_READ;
      else if (stateNext == ST_IDLE)    mode <= OUT_STATUS;
      else                              mode <= OUT_OFF;
    end
  end

endmodule

// File: rtl/sereep_dp.sv
module sereep_dp
  import sereep_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dS,
  input  dpStrobe_t  stb,
  output logic [1:0] addrHigh,
  output logic       readBit
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int RC_W  = $clog2(DATA_W);

  logic [ADDR_W-1:0] addrReg, addrNext, readPtr, ptrInc;
  logic [DATA_W-1:0] dataReg, readShift;
  logic [RC_W-1:0]   readCnt;
  logic [DATA_W-1:0] mem [DEPTH];

  assign addrNext = {addrReg[ADDR_W-2:0], dS};
  assign ptrInc   = readPtr + 1'b1;
  assign addrHigh = addrReg[ADDR_W-2 -: 2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg   <= '0;
      dataReg   <= '0;
      readPtr   <= '0;
      readShift <= '0;
      readCnt   <= '0;
      readBit   <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (stb.addrShift) addrReg <= addrNext;
      if (stb.dataShift) dataReg <= {dataReg[DATA_W-2:0], dS};
      if (stb.readLoad) begin
        readPtr   <= addrNext;
        readShift <= mem[addrNext];
        readCnt   <= '0;
        readBit   <= 1'b0;
      end else if (stb.readStep) begin
        readBit <= readShift[DATA_W-1];
        if (readCnt == RC_W'(DATA_W - 1)) begin
          readPtr   <= ptrInc;
          readShift <= mem[ptrInc];
          readCnt   <= '0;
        end else begin
          readShift <= {readShift[DATA_W-2:0], 1'b0};
          readCnt   <= readCnt + 1'b1;
        end
      end
      if (stb.memWrite) mem[addrReg] <= stb.eraseSel ? '1 : dataReg;
    end
  end

endmodule

// File: rtl/sereep_seq.sv
module sereep_seq
  import sereep_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csIn,
  input  logic sclkIn,
  input  logic dIn,
  input  logic weIn,
  output logic doOut,
  output logic doOe
);

  logic [3:0] syncBus;
  logic       csSync, sclkSync, dSync, weSync;
  dpStrobe_t  stb;
  outMode_t   mode;
  logic       progBusy, welLatch, readBit;
  logic [1:0] addrHigh;

  sereep_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .rawIn   ({weIn, dIn, sclkIn, csIn}),
    .syncOut (syncBus)
  );

  assign {weSync, dSync, sclkSync, csSync} = syncBus;

  sereep_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .csS      (csSync),
    .sclkS    (sclkSync),
    .dS       (dSync),
    .weS      (weSync),
    .addrHigh (addrHigh),
    .stb      (stb),
    .mode     (mode),
    .progBusy (progBusy),
    .welLatch (welLatch)
  );

  sereep_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .dS       (dSync),
    .stb      (stb),
    .addrHigh (addrHigh),
    .readBit  (readBit)
  );

  assign doOe  = (mode != OUT_OFF);
  assign doOut = (mode == OUT_STATUS) ? ~progBusy : readBit;

endmodule

// File: rtl/sereep_seq_chk.sv
module sereep_seq_chk #(
  parameter int PROG_CYCLES = 400
) (
  input logic clk,
  input logic rstN,
  input logic csS,
  input logic weS,
  input logic busy,
  input logic welLatch,
  input logic doOe,
  input logic doOut
);

  localparam int CW = $clog2(PROG_CYCLES + 2) + 1;

  logic [CW-1:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 1'b1;
    else           busyCnt <= '0;
  end

  AST_BUSY_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (doOe && busy) |-> !doOut); // R9

  AST_LAUNCH_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> welLatch); // R5

  AST_LAUNCH_ON_CS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !csS); // R8

  AST_LAUNCH_NEEDS_WE_PIN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(weS)); // R7

  AST_OE_FOLLOWS_CS: assert property (@(posedge clk) disable iff (!rstN)
    doOe |-> $past(csS)); // R12

  AST_PROG_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyCnt == CW'(PROG_CYCLES))); // R10

endmodule

bind sereep_seq sereep_seq_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .csS      (csSync),
  .weS      (weSync),
  .busy     (progBusy),
  .welLatch (welLatch),
  .doOe     (doOe),
  .doOut    (doOut)
);

// File: tb/sereep_seq_tb.sv
module sereep_seq_tb;

  localparam int HALF = 8;
  localparam int PROG = 400;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cs = 1'b0, sclk = 1'b0, d = 1'b0, we = 1'b1;
  logic doOut, doOe;
  int   vecCount = 0, missCount = 0;
  int   cyc = 0;
  bit   finished = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sereep_seq u_dut (
    .clk(clk), .rstN(rstN), .csIn(cs), .sclkIn(sclk),
    .dIn(d), .weIn(we), .doOut(doOut), .doOe(doOe)
  );

  // {isRead, addr, data}
  localparam logic [24:0] VEC [8] = '{
    {1'b0, 8'h00, 16'hA5C3},
    {1'b0, 8'hFF, 16'h1234},
    {1'b0, 8'h01, 16'hBEEF},
    {1'b0, 8'h7E, 16'h0F0F},
    {1'b1, 8'h00, 16'hA5C3},
    {1'b1, 8'h01, 16'hBEEF},
    {1'b1, 8'h7E, 16'h0F0F},
    {1'b1, 8'hFF, 16'h1234}
  };

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vecCount++;
    if (got !== exp) begin
      missCount++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic pulse(input logic b);
    d = b;
    waitClk(2);
    sclk = 1'b1;
    waitClk(HALF);
    sclk = 1'b0;
    waitClk(HALF);
  endtask

  task automatic csUp();
    cs = 1'b1;
    waitClk(4);
  endtask

  task automatic csDown();
    cs = 1'b0;
    waitClk(2 * HALF);
  endtask

  task automatic sendHead(input logic [1:0] op, input logic [7:0] addr);
    pulse(1'b1);
    pulse(op[1]);
    pulse(op[0]);
    for (int i = 7; i >= 0; i--) pulse(addr[i]);
  endtask

  task automatic waitReady();
    for (int i = 0; i < 2000; i++) begin
      if (doOut === 1'b1) break;
      waitClk(1);
    end
  endtask

  task automatic finishLaunch(input bit expectLaunch, input string tag);
    csUp();
    if (expectLaunch) begin
      check({tag, " busy"}, {doOe, doOut}, 2'b10);
      waitReady();
    end else begin
      check({tag, " no launch"}, {doOe, doOut}, 2'b11);
    end
    csDown();
  endtask

  task automatic writeWord(input logic [7:0] addr, input logic [15:0] data,
                           input int dropAt, input bit extra,
                           input bit expectLaunch, input string tag);
    csUp();
    sendHead(2'b01, addr);
    for (int i = 15; i >= 0; i--) begin
      if (i == dropAt) we = 1'b0;
      pulse(data[i]);
      we = 1'b1;
    end
    if (extra) pulse(1'b0);
    csDown();
    finishLaunch(expectLaunch, tag);
  endtask

  task automatic latchCmd(input logic [7:0] addr);
    csUp();
    sendHead(2'b00, addr);
    csDown();
  endtask

  task automatic readFirst(input logic [7:0] addr, input int lead, input string tag);
    csUp();
    for (int i = 0; i < lead; i++) pulse(1'b0);
    sendHead(2'b10, addr);
    check({tag, " dummy"}, {doOe, doOut}, 2'b10);
  endtask

  task automatic getWord(output logic [15:0] w);
    for (int i = 15; i >= 0; i--) begin
      pulse(1'b0);
      w[i] = doOut;
    end
  endtask

  task automatic readOne(input logic [7:0] addr, input logic [15:0] exp, input string tag);
    logic [15:0] w;
    readFirst(addr, 0, tag);
    getWord(w);
    check(tag, w, exp);
    csDown();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
  endtask

  initial begin
    logic [15:0] w;
    int t0;
    int elapsed;
    waitClk(5);
    rstN = 1'b1;
    waitClk(4);

    // R1: output disabled after reset
    check("R1 oe after reset", doOe, 1'b0);
    // R10: ready status when idle
    csUp();
    check("R10 idle ready", {doOe, doOut}, 2'b11);
    csDown();
    // R5 / R1: latch clear after reset, write ignored
    writeWord(8'h10, 16'h5555, -1, 1'b0, 1'b0, "R5 write before enable");
    readOne(8'h10, 16'h0000, "R1 cleared storage");

    // R5: set latch, then table of writes and reads (R3)
    latchCmd(8'hC0);
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][24]) readOne(VEC[i][23:16], VEC[i][15:0], "R3 read word");
      else            writeWord(VEC[i][23:16], VEC[i][15:0], -1, 1'b0, 1'b1, "R5 table write");
    end

    // R2: leading zeros before start bit; R4: stream with wrap
    readFirst(8'hFF, 2, "R2 leading zeros");
    getWord(w);
    check("R2 word after leading zeros", w, 16'h1234);
    getWord(w);
    check("R4 wrap to address zero", w, 16'hA5C3);
    getWord(w);
    check("R4 next word no gap", w, 16'hBEEF);
    // R12: output released on chip select low
    cs = 1'b0;
    waitClk(5);
    check("R12 oe released", doOe, 1'b0);
    waitClk(2 * HALF);

    // R9 / R10: commands ignored during programming, duration, resume
    csUp();
    sendHead(2'b01, 8'h40);
    for (int i = 15; i >= 0; i--) pulse(i[0] ? 1'b1 : 1'b0); // 16'hAAAA
    cs = 1'b0;
    t0 = cyc;
    waitClk(2 * HALF);
    cs = 1'b1;
    waitClk(4);
    check("R9 busy on raise", {doOe, doOut}, 2'b10);
    sendHead(2'b10, 8'h00);
    pulse(1'b0);
    check("R9 read ignored while busy", {doOe, doOut}, 2'b10);
    waitReady();
    elapsed = cyc - t0;
    check("R10 programming length", (elapsed >= PROG && elapsed <= PROG + 10), 1'b1);
    sendHead(2'b10, 8'h40);
    check("R10 accepted after ready", {doOe, doOut}, 2'b10);
    getWord(w);
    check("R10 read after ready", w, 16'hAAAA);
    csDown();

    // R8: extra clock edge cancels the write
    writeWord(8'h7E, 16'h3C3C, -1, 1'b1, 1'b0, "R8 extra edge");
    readOne(8'h7E, 16'h0F0F, "R8 word unchanged");

    // R7: write-enable pin dropped mid-data
    writeWord(8'h01, 16'h0000, 5, 1'b0, 1'b0, "R7 pin low");
    readOne(8'h01, 16'hBEEF, "R7 word unchanged");

    // R11: erase
    csUp();
    sendHead(2'b11, 8'h01);
    csDown();
    finishLaunch(1'b1, "R11 erase");
    readOne(8'h01, 16'hFFFF, "R11 erased word");

    // R5 / R6: clear latch, write ignored, read still works
    latchCmd(8'h00);
    writeWord(8'h00, 16'h5A5A, -1, 1'b0, 1'b0, "R5 write after disable");
    readOne(8'h00, 16'hA5C3, "R6 read with latch clear");

    // R12: chip select low mid-frame ends the command
    csUp();
    sendHead(2'b10, 8'h7E);
    pulse(1'b0);
    csDown();
    check("R12 oe off after abort", doOe, 1'b0);
    csUp();
    check("R12 fresh status after abort", {doOe, doOut}, 2'b11);
    csDown();

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      missCount++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule